// File: doc/BRIEF.md
# Configurable General-Purpose I/O Port

This block is a memory-mapped general-purpose I/O port of up to sixteen pins. Each pin has four controls, held in separate registers: a direction bit, an output latch bit, an open-drain enable and an analog-select bit. Software writes and reads these through a small register bus with a write strobe, an address, write data and read data. Pad circuits, pull-up resistors and the converter behind the analog pins are outside the block. It only decides what each pin drives and what a port read returns.

On the pad side the block produces a drive enable and a drive value for every pin. It takes back the pin level, which passes through a two-flop synchronizer and a capture register before software can read it. A pin can be marked analog, and a port read then returns zero for it. A pin without analog capability can be switched to open-drain drive: it pulls low, and it is released instead of driven high. A parameter mask says which pins have analog capability.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset, no pin is driven (`pad_oe` all zero). The direction register reads all ones, and the latch and open-drain registers read zero. The analog register reads 0 on every analog-capable pin (`ANA_MASK` bit 1, default 16'h0F0F) and 1 on every other pin.
- R2: A pin whose direction bit is 1 is an input, and its `pad_oe` bit is 0 whatever the other controls hold.
- R3: A pin with direction bit 0 in push-pull drive has `pad_oe` at 1 and `pad_out` equal to its latch bit.
- R4: A pin without analog capability, with direction bit 0 and open-drain bit 1, has `pad_out` at 0 and `pad_oe` equal to the inverse of its latch bit.
- R5: The open-drain bit has no effect on analog-capable pins. As outputs they always use push-pull drive.
- R6: A port read returns 0 for every analog-capable pin whose analog bit is 0. The masking follows the analog register in the same cycle that the register changes.
- R7: A port read of a digital pin returns the `pad_in` level sampled three rising edges earlier (two synchronizer stages and one capture register). Until three edges have passed after reset, the value is 0.
- R8: A latch read returns the latch register, not the pin level. A released open-drain pin held low outside the block still reads back as 1.
- R9: A write happens on a rising edge with `bus_we` high. The addresses are: 0 direction, 1 latch, 2 port (read-only, so writes there are ignored), 3 open-drain and 4 analog. Addresses 5 to 7 read 0 and ignore writes. `bus_rdata` is combinational from `bus_addr`.
- R10: The analog bits of pins without analog capability always read 1, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | N | Write data, one bit per pin |
| bus_rdata | output | N | Read data for the selected register |
| pad_in | input | N | Pin levels from the pads |
| pad_oe | output | N | Per-pin drive enable |
| pad_out | output | N | Per-pin drive value |

## Verification
Two things can fall in the same cycle: a write to the analog register, and a port read of a pin whose input is changing in the synchronizer. The bench provokes this by changing `pad_in` on the same edge that clears or sets analog bits while the port address is selected. The read must show the new mask at once and the new pin level only three edges later. Another collision is a latch write to an open-drain pin whose external level disagrees. It is judged by reading the latch back (the written value) and the port (the pin level), both against a behavioural model that is compared on every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 3'd0,
        SEL_LAT  = 3'd1,
        SEL_PORT = 3'd2,
        SEL_ODC  = 3'd3,
        SEL_ANA  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drv_t;

    typedef enum logic [1:0] {
        MODE_INPUT,
        MODE_PUSH,
        MODE_OPEN
    } pin_mode_e;

    // Pick the drive mode of one pin from its controls.
    function automatic pin_mode_e mode_of(logic is_in, logic od_eff);
        pin_mode_e m;
        if (is_in)       m = MODE_INPUT;
        else if (od_eff) m = MODE_OPEN;
        else             m = MODE_PUSH;
        return m;
    endfunction

    // Turn a mode and a latch bit into the pad drive.
    function automatic pin_drv_t drive_of(pin_mode_e m, logic lat);
        pin_drv_t d;
        unique case (m)
            MODE_PUSH: begin d.oe = 1'b1; d.val = lat;  end
            MODE_OPEN: begin d.oe = ~lat; d.val = 1'b0; end
            default:   begin d.oe = 1'b0; d.val = 1'b0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int              N        = 16,
    parameter logic [N-1:0]    ANA_MASK = 16'h0F0F
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  reg_sel_e             sel,
    input  logic [N-1:0]         wdata,
    output logic [N-1:0]         dir_q,
    output logic [N-1:0]         lat_q,
    output logic [N-1:0]         odc_q,
    output logic [N-1:0]         ana_q
);

    // Non-capable analog bits are forced to one.
    localparam logic [N-1:0] ANA_FIXED = ~ANA_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            lat_q <= '0;
            odc_q <= '0;
            ana_q <= ANA_FIXED;
        end else if (we) begin
            case (sel)
                SEL_DIR: dir_q <= wdata;
                SEL_LAT: lat_q <= wdata;
                SEL_ODC: odc_q <= wdata;
                SEL_ANA: ana_q <= wdata | ANA_FIXED;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_drive.sv
module gpio_drive
    import gpio_pkg::*;
#(
    parameter int           N        = 16,
    parameter logic [N-1:0] ANA_MASK = 16'h0F0F
) (
    input  logic [N-1:0] dir_q,
    input  logic [N-1:0] lat_q,
    input  logic [N-1:0] odc_q,
    output logic [N-1:0] pad_oe,
    output logic [N-1:0] pad_out
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        pin_drv_t drv;
        if (ANA_MASK[i]) begin : g_analog_capable
            // Open-drain has no meaning here: push-pull only.
            logic unused_odc;
            assign unused_odc = odc_q[i];
            assign drv = drive_of(mode_of(dir_q[i], 1'b0), lat_q[i]);
        end else begin : g_digital_only
            assign drv = drive_of(mode_of(dir_q[i], odc_q[i]), lat_q[i]);
        end
        assign pad_oe[i]  = drv.oe;
        assign pad_out[i] = drv.val;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] port_q
);

    logic [N-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= (s == 0) ? pad_in : chain[(s == 0) ? 0 : s-1];
        end
    end

    // Capture register that software reads.
    always_ff @(posedge clk) begin
        if (rst) port_q <= '0;
        else     port_q <= chain[STAGES-1];
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int           N        = 16,
    parameter logic [N-1:0] ANA_MASK = 16'h0F0F
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [N-1:0]        bus_wdata,
    output logic [N-1:0]        bus_rdata,
    input  logic [N-1:0]        pad_in,
    output logic [N-1:0]        pad_oe,
    output logic [N-1:0]        pad_out
);

    reg_sel_e     sel;
    logic [N-1:0] dir_q, lat_q, odc_q, ana_q;
    logic [N-1:0] port_q;
    logic [N-1:0] analog_pins;

    assign sel = reg_sel_e'(bus_addr);

    gpio_regs #(.N(N), .ANA_MASK(ANA_MASK)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .sel   (sel),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .lat_q (lat_q),
        .odc_q (odc_q),
        .ana_q (ana_q)
    );

    gpio_drive #(.N(N), .ANA_MASK(ANA_MASK)) drive_i (
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .odc_q   (odc_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    gpio_in_sync #(.N(N), .STAGES(2)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .port_q (port_q)
    );

    // Analog masking is applied at read time against the live register.
    assign analog_pins = ANA_MASK & ~ana_q;

    always_comb begin
        case (sel)
            SEL_DIR:  bus_rdata = dir_q;
            SEL_LAT:  bus_rdata = lat_q;
            SEL_PORT: bus_rdata = port_q & ~analog_pins;
            SEL_ODC:  bus_rdata = odc_q;
            SEL_ANA:  bus_rdata = ana_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int           N        = 16,
    parameter logic [N-1:0] ANA_MASK = 16'h0F0F
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_we,
    input logic [2:0]   bus_addr,
    input logic [N-1:0] bus_wdata,
    input logic [N-1:0] bus_rdata,
    input logic [N-1:0] pad_in,
    input logic [N-1:0] pad_oe,
    input logic [N-1:0] pad_out,
    input logic [N-1:0] dir_q,
    input logic [N-1:0] lat_q,
    input logic [N-1:0] odc_q,
    input logic [N-1:0] ana_q
);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (pad_oe == '0));

    // R2
    input_undriven_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & dir_q) == '0);

    // R3
    push_pull_chk: assert property (@(posedge clk) disable iff (rst)
        ((~dir_q & ~(odc_q & ~ANA_MASK)) & (~pad_oe | (pad_out ^ lat_q))) == '0);

    // R4
    open_drain_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_out & odc_q & ~ANA_MASK) == '0);

    // R5
    analog_no_od_chk: assert property (@(posedge clk) disable iff (rst)
        ((ANA_MASK & ~dir_q) & (~pad_oe | (pad_out ^ lat_q))) == '0);

    // R6
    analog_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd2) |-> ((bus_rdata & ANA_MASK & ~ana_q) == '0));

    // R7
    port_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd2 && since_rst == 2'd3)
        |-> (bus_rdata == ($past(pad_in, 3) & ~(ANA_MASK & ~ana_q))));

    // R8
    latch_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd1) |=> (lat_q == $past(bus_wdata)));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > 3'd4) |-> (bus_rdata == '0));

    // R10
    fixed_analog_chk: assert property (@(posedge clk) disable iff (rst)
        (ana_q | ANA_MASK) == '1);

endmodule

bind gpio_port gpio_port_chk #(.N(N), .ANA_MASK(ANA_MASK)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .dir_q     (dir_q),
    .lat_q     (lat_q),
    .odc_q     (odc_q),
    .ana_q     (ana_q)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;

    localparam int          N    = 16;
    localparam logic [15:0] MASK = 16'h0F0F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_oe;
    logic [N-1:0]  pad_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_port #(.N(N), .ANA_MASK(MASK)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // ---------------- behavioural reference ----------------
    logic [N-1:0] m_dir, m_lat, m_odc, m_ana;
    logic [N-1:0] hist [$];

    always @(posedge clk) begin
        if (rst) begin
            m_dir = '1; m_lat = '0; m_odc = '0; m_ana = ~MASK;
            hist.delete();
        end else begin
            hist.push_front(pad_in);
            if (hist.size() > 3) void'(hist.pop_back());
            if (bus_we) begin
                if (bus_addr == 3'd0) m_dir = bus_wdata;
                if (bus_addr == 3'd1) m_lat = bus_wdata;
                if (bus_addr == 3'd3) m_odc = bus_wdata;
                if (bus_addr == 3'd4) m_ana = bus_wdata | ~MASK;
            end
        end
    end

    function automatic logic [N-1:0] exp_oe();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (m_dir[i])                      r[i] = 1'b0;
            else if (m_odc[i] && !MASK[i])     r[i] = ~m_lat[i];
            else                               r[i] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [N-1:0] exp_out();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (m_dir[i] || (m_odc[i] && !MASK[i])) r[i] = 1'b0;
            else                                     r[i] = m_lat[i];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] exp_rd(logic [2:0] a);
        logic [N-1:0] p;
        p = (hist.size() >= 3) ? hist[2] : '0;
        case (a)
            3'd0:    return m_dir;
            3'd1:    return m_lat;
            3'd2:    return p & ~(MASK & ~m_ana);
            3'd3:    return m_odc;
            3'd4:    return m_ana;
            default: return '0;
        endcase
    endfunction

    task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Model comparison on every clock (R2 R3 R4 R5 drive, R6 R7 R9 read).
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3 pad_oe vs model",  pad_oe,    exp_oe());
            check("R4 pad_out vs model", pad_out,   exp_out());
            check("R9 bus_rdata vs model", bus_rdata, exp_rd(bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [2:0] a, logic [N-1:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [2:0] a, logic [N-1:0] exp);
        bus_addr = a;
        @(negedge clk);
        check(tag, bus_rdata, exp);
        step();
    endtask

    task automatic pin_check(string tag, logic [N-1:0] eoe, logic [N-1:0] eout);
        @(negedge clk);
        check({tag, " oe"}, pad_oe, eoe);
        check({tag, " out"}, pad_out, eout);
        step();
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1: reset state
        pin_check("R1 reset", 16'h0000, 16'h0000);
        rd_check("R1 dir reset", 3'd0, 16'hFFFF);
        rd_check("R1 lat reset", 3'd1, 16'h0000);
        rd_check("R1 odc reset", 3'd3, 16'h0000);
        rd_check("R1 ana reset", 3'd4, 16'hF0F0);

        // R6: analog pins read zero
        pad_in = 16'hFFFF;
        repeat (4) step();
        rd_check("R6 analog masked", 3'd2, 16'hF0F0);

        // R10: fixed analog bits
        wr(3'd4, 16'h0000);
        rd_check("R10 fixed bits", 3'd4, 16'hF0F0);

        // R6: mask follows register in the same cycle
        bus_addr = 3'd2;
        wr(3'd4, 16'hFFFF);
        bus_addr = 3'd2;
        @(negedge clk);
        check("R6 unmask same cycle", bus_rdata, 16'hFFFF);
        step();

        // R7: three-edge latency
        bus_addr = 3'd2;
        pad_in = 16'h1234;
        step();
        @(negedge clk); check("R7 edge1 old", bus_rdata, 16'hFFFF);
        step();
        @(negedge clk); check("R7 edge2 old", bus_rdata, 16'hFFFF);
        step();
        @(negedge clk); check("R7 edge3 new", bus_rdata, 16'h1234);
        step();

        // R3: push-pull outputs
        wr(3'd1, 16'hA5C3);
        wr(3'd0, 16'h0000);
        pin_check("R3 push-pull", 16'hFFFF, 16'hA5C3);

        // R4 / R5: open-drain on digital-only pins, ignored on analog-capable
        wr(3'd3, 16'hFFFF);
        pin_check("R4 open-drain", 16'h5F3F, 16'h0503);

        // R2: inputs released
        wr(3'd0, 16'h00FF);
        pin_check("R2 inputs", 16'h5F00, 16'h0500);

        // R8: latch reads latch, not pin
        pad_in = 16'h0000;
        repeat (4) step();
        rd_check("R8 latch readback", 3'd1, 16'hA5C3);
        rd_check("R8 port shows pin", 3'd2, 16'h0000);

        // R9: port write ignored, unmapped addresses
        wr(3'd2, 16'h0000);
        rd_check("R9 port write ignored", 3'd1, 16'hA5C3);
        wr(3'd5, 16'hFFFF);
        wr(3'd7, 16'h1111);
        rd_check("R9 unmapped reads zero", 3'd6, 16'h0000);
        rd_check("R9 dir unchanged", 3'd0, 16'h00FF);

        // Collision: analog write with pin change while reading the port (R6 R7)
        bus_addr = 3'd2;
        pad_in = 16'hFFFF;
        bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 16'h0F00;
        step();
        bus_we = 1'b0; bus_addr = 3'd2;
        repeat (4) step();

        // Free-running mixed traffic checked by the model every clock
        for (int k = 0; k < 400; k++) begin
            pad_in    = N'($urandom);
            bus_addr  = 3'($urandom_range(0, 7));
            bus_wdata = N'($urandom);
            bus_we    = ($urandom_range(0, 3) == 0);
            step();
        end
        bus_we = 1'b0;
        step();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule